// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block holds the tap position of a 64-step resistor ladder and turns it into the switch enables for that ladder. The position is a 6-bit register. Four sources can set it: a value shifted in by a serial front end, a copy of one of four stored data words, single up or down steps, and a recall of stored word 0. The recall is what happens at power-up. The serial protocol engine and the nonvolatile store sit outside this block. They reach it only through plain load, step and recall strobes, plus a flat bus that carries the four stored words.

The switch enable vector always has exactly one bit set, and that bit sits at the index equal to the position. Position 0 closes the switch at the low end of the ladder. Position 63 closes the switch at the high end. Steps stop at either end and never wrap. The register does not survive power loss: a synchronous reset stands in for power-up and loads stored word 0, not the last position held.

If several strobes arrive in the same cycle, a fixed priority picks one of them. The write-protect input guards the nonvolatile store only, so this register ignores it.

Top module: `wiper_pos_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the position loads stored word 0, which is `bank_data[5:0]`.
- R2: `tap_en` always has exactly one bit set, and that bit's index equals `pos`.
- R3: `pos` = 6'h00 sets only `tap_en[0]`, the low-terminal switch. `pos` = 6'h3F sets only `tap_en[63]`, the high-terminal switch.
- R4: A cycle with `ser_load` high makes `pos` equal `ser_val` after the next rising edge.
- R5: A cycle with `bank_load` high makes `pos` equal the stored word picked by `bank_sel`. Word k sits at `bank_data[6k+5:6k]`.
- R6: A cycle with `recall` high makes `pos` equal stored word 0 after the next rising edge.
- R7: With `step` high, `step_up` = 1 adds one and `step_up` = 0 subtracts one. An up step at 6'h3F leaves 6'h3F, and a down step at 6'h00 leaves 6'h00.
- R8: If strobes coincide, the winner is `recall` first, then `bank_load`, then `ser_load`, then `step`.
- R9: `prot_n` has no effect. Loads, steps and recall behave the same with it low as with it high.
- R10: In a cycle with no strobe, `pos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads stored word 0 |
| recall | input | 1 | Strobe: load stored word 0 |
| bank_load | input | 1 | Strobe: load the stored word picked by `bank_sel` |
| bank_sel | input | 2 | Index of the stored word to load |
| bank_data | input | 24 | Four stored 6-bit words; word k at bits 6k+5:6k |
| ser_load | input | 1 | Strobe: load `ser_val` |
| ser_val | input | 6 | Position value from the serial front end |
| step | input | 1 | Strobe: move one tap |
| step_up | input | 1 | Step direction: 1 toward the high end, 0 toward the low end |
| prot_n | input | 1 | Write-protect level; ignored by this register |
| pos | output | 6 | Current position, for readback |
| tap_en | output | 64 | One-hot ladder switch enables |

## Verification
Any pair of the four strobes can fire in the same clock cycle. The most telling pairs are a bank copy against a serial value, a serial value against a step, and a recall against a bank copy. In the vector table these pairs are driven together with differing operands, so the position that results shows which source won. Each vector is then judged against the value of the higher-priority source alone. Steps are driven into both ends of the range to check that they saturate. The write-protect input is held active through the whole table, so every load and step is exercised with protection asserted.

// File: rtl/wpos_pkg.sv
// Package: shared widths and the load-source encoding for the wiper
// position register. Assumes a single ladder with a power-of-two tap count.
package wpos_pkg;
    localparam int POS_W    = 6;
    localparam int NUM_BANK = 4;
    localparam int TAPS     = 1 << POS_W;

    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_RECALL = 3'd1,
        SRC_BANK   = 3'd2,
        SRC_SER    = 3'd3,
        SRC_STEP   = 3'd4
    } wpos_src_e;
endpackage

// File: rtl/wpos_step.sv
// Module: one-tap saturating stepper. Produces pos +/- 1, clamped at the
// two ends of the code range. Assumes an unsigned position code.
module wpos_step #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] cur,
    input  logic             up,
    output logic [POS_W-1:0] stepped
);
    localparam logic [POS_W-1:0] TOP = '1;
    localparam logic [POS_W-1:0] BOT = '0;

    // Move one code in the asked direction unless already at that end.
    always_comb begin
        if (up)
            stepped = (cur == TOP) ? cur : cur + POS_W'(1);
        else
            stepped = (cur == BOT) ? cur : cur - POS_W'(1);
    end
endmodule

// File: rtl/wpos_next.sv
// Module: next-position selector. Arbitrates the strobes with fixed
// priority recall > bank > serial > step and returns the chosen source
// and value. Assumes bank words are packed low index first.
module wpos_next
    import wpos_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    localparam int SEL_W   = $clog2(NUM_BANK)
) (
    input  logic [POS_W-1:0]          cur,
    input  logic                      recall,
    input  logic                      bank_load,
    input  logic [SEL_W-1:0]          bank_sel,
    input  logic [NUM_BANK*POS_W-1:0] bank_data,
    input  logic                      ser_load,
    input  logic [POS_W-1:0]          ser_val,
    input  logic [POS_W-1:0]          stepped,
    input  logic                      step,
    output wpos_src_e                 src,
    output logic [POS_W-1:0]          nxt
);
    logic [POS_W-1:0] word0;
    logic [POS_W-1:0] picked;

    // Extract stored word 0 and the word named by the selector.
    always_comb begin
        word0  = bank_data[POS_W-1:0];
        picked = bank_data[bank_sel*POS_W +: POS_W];
    end

    // Fixed-priority choice of the load source.
    always_comb begin
        if (recall)         src = SRC_RECALL;
        else if (bank_load) src = SRC_BANK;
        else if (ser_load)  src = SRC_SER;
        else if (step)      src = SRC_STEP;
        else                src = SRC_HOLD;
    end

    // Map the chosen source to its value.
    always_comb begin
        unique case (src)
            SRC_RECALL: nxt = word0;
            SRC_BANK:   nxt = picked;
            SRC_SER:    nxt = ser_val;
            SRC_STEP:   nxt = stepped;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/wpos_tap_decode.sv
// Module: binary-to-one-hot tap decoder. Enables the single ladder switch
// whose index equals the position; index 0 is the low end.
module wpos_tap_decode #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_en
);
    // One comparator per switch.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        always_comb tap_en[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/wiper_pos_reg.sv
// Module: volatile wiper position register with recall, bank copy, serial
// load and saturating steps, driving a one-hot switch vector. Reset stands
// for power-up and recalls stored word 0. Assumes strobes are one-cycle
// level pulses synchronous to clk; prot_n guards only external storage.
module wiper_pos_reg
    import wpos_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    localparam int SEL_W   = $clog2(NUM_BANK),
    localparam int TAPS    = 1 << POS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recall,
    input  logic                      bank_load,
    input  logic [SEL_W-1:0]          bank_sel,
    input  logic [NUM_BANK*POS_W-1:0] bank_data,
    input  logic                      ser_load,
    input  logic [POS_W-1:0]          ser_val,
    input  logic                      step,
    input  logic                      step_up,
    input  logic                      prot_n,
    output logic [POS_W-1:0]          pos,
    output logic [TAPS-1:0]           tap_en
);
    localparam logic [POS_W-1:0] TOP = '1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] stepped;
    logic [POS_W-1:0] nxt;
    wpos_src_e        src;

    wpos_step #(.POS_W(POS_W)) u_step (
        .cur     (pos_q),
        .up      (step_up),
        .stepped (stepped)
    );

    wpos_next #(.POS_W(POS_W), .NUM_BANK(NUM_BANK)) u_next (
        .cur       (pos_q),
        .recall    (recall),
        .bank_load (bank_load),
        .bank_sel  (bank_sel),
        .bank_data (bank_data),
        .ser_load  (ser_load),
        .ser_val   (ser_val),
        .stepped   (stepped),
        .step      (step),
        .src       (src),
        .nxt       (nxt)
    );

    // Position register; reset recalls stored word 0.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= bank_data[POS_W-1:0];
        else        pos_q <= nxt;
    end

    wpos_tap_decode #(.POS_W(POS_W)) u_dec (
        .pos    (pos_q),
        .tap_en (tap_en)
    );

    // Drive the readback port.
    always_comb pos = pos_q;

    assert_reset_recall_R1: assert property (@(posedge clk)
        !rst_n |=> pos == $past(bank_data[POS_W-1:0]));

    assert_one_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_en) == 1 && tap_en[pos]);

    assert_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) == tap_en[0] && (pos == TOP) == tap_en[TAPS-1]);

    assert_recall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recall |=> pos == $past(bank_data[POS_W-1:0]));

    assert_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && bank_load) |=> pos == $past(bank_data[bank_sel*POS_W +: POS_W]));

    assert_ser_under_prot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !bank_load && ser_load && !prot_n) |=> pos == $past(ser_val));

    assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !bank_load && !ser_load && step && step_up && pos == TOP) |=> pos == TOP);

    assert_sat_bot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !bank_load && !ser_load && step && !step_up && pos == '0) |=> pos == '0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !bank_load && !ser_load && !step) |=> $stable(pos));
endmodule

// File: tb/wiper_pos_reg_bench.sv
// Bench: table-driven strobe vectors, then directed reset and end checks.
module wiper_pos_reg_bench;
    localparam int CLK_PERIOD = 10;
    // vector: {recall, bank_load, bank_sel[1:0], ser_load, step, step_up, ser_val[5:0], expect[5:0]}
    localparam int NV = 16;
    localparam logic [18:0] VECS [0:NV-1] = '{
        {1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,6'h3E,6'h3E}, // R4 serial load
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b1,6'h00,6'h3F}, // R7 up
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b1,6'h00,6'h3F}, // R7 up saturates
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,6'h00,6'h3E}, // R7 down
        {1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,6'h00,6'h00}, // R5 bank 2
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,6'h00,6'h00}, // R7 down saturates
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b1,6'h00,6'h01}, // R7 up from 0
        {1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,6'h22,6'h01}, // R10 hold
        {1'b0,1'b1,2'd3,1'b1,1'b0,1'b0,6'h10,6'h2A}, // R8 bank over serial
        {1'b0,1'b0,2'd0,1'b1,1'b1,1'b1,6'h10,6'h10}, // R8 serial over step
        {1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,6'h00,6'h15}, // R8 recall over bank
        {1'b0,1'b1,2'd1,1'b0,1'b1,1'b0,6'h00,6'h3F}, // R8 bank over step
        {1'b1,1'b0,2'd0,1'b1,1'b1,1'b1,6'h05,6'h15}, // R6 recall over all
        {1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,6'h00,6'h14}, // R7 down
        {1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,6'h00,6'h15}, // R5 bank 0
        {1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,6'h07,6'h07}  // R9 serial under protect
    };

    logic        clk = 1'b0;
    logic        rst_n, recall, bank_load, ser_load, step, step_up, prot_n;
    logic [1:0]  bank_sel;
    logic [23:0] bank_data;
    logic [5:0]  ser_val, pos;
    logic [63:0] tap_en;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    wiper_pos_reg u_wiper_pos_reg (
        .clk(clk), .rst_n(rst_n), .recall(recall), .bank_load(bank_load),
        .bank_sel(bank_sel), .bank_data(bank_data), .ser_load(ser_load),
        .ser_val(ser_val), .step(step), .step_up(step_up), .prot_n(prot_n),
        .pos(pos), .tap_en(tap_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        n_vec++;
        if (pos !== exp || tap_en !== (64'd1 << exp)) begin
            n_bad++;
            $display("FAIL %s: pos=%h tap_en=%h expected pos=%h tap_en=%h",
                     req, pos, tap_en, exp, 64'd1 << exp);
        end
    endtask

    task automatic idle_strobes();
        recall = 0; bank_load = 0; ser_load = 0; step = 0; step_up = 0;
        bank_sel = 2'd0; ser_val = 6'h00;
    endtask

    initial begin
        #(CLK_PERIOD*2000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        idle_strobes();
        prot_n = 1'b0;
        bank_data = {6'h2A, 6'h00, 6'h3F, 6'h15};
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 reset recalls word 0", 6'h15);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 hold after reset", 6'h15);

        for (int i = 0; i < NV; i++) begin
            {recall, bank_load, bank_sel, ser_load, step, step_up, ser_val} = VECS[i][18:6];
            @(negedge clk);
            check($sformatf("R8/R4-R7 vector %0d", i), VECS[i][5:0]);
        end
        idle_strobes();

        // R9: same serial load with protect released gives the same result.
        prot_n = 1'b1; ser_load = 1; ser_val = 6'h3F;
        @(negedge clk);
        check("R9 serial with prot_n high", 6'h3F);
        ser_load = 0; step = 1; step_up = 1;
        @(negedge clk);
        check("R3 high end stays and uses tap 63", 6'h3F);
        step = 0; prot_n = 1'b0; ser_load = 1; ser_val = 6'h00;
        @(negedge clk);
        check("R3 low end uses tap 0", 6'h00);
        ser_load = 0;

        // R6: recall follows a changed word 0.
        bank_data[5:0] = 6'h33; recall = 1;
        @(negedge clk);
        check("R6 recall of new word 0", 6'h33);
        recall = 0; step = 1; step_up = 1;
        @(negedge clk);
        check("R2 one tap after step", 6'h34);
        step = 0;

        // R1: reset mid-run returns to stored word 0, not the last position.
        bank_data[5:0] = 6'h09; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 6'h09);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 hold", 6'h09);
        finish_run();
    end
endmodule